// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level half of a serial flash controller. It turns 32-bit words from a transmit FIFO into a single-lane SPI bit stream and gathers the bits coming back into words for a receive FIFO. The serial clock comes from the reference clock through a power-of-two divider. Clock polarity and clock phase can each be chosen. The chip select line is driven only by a software force bit, so a sequence of several words forms one transaction for as long as software keeps the line low.

Each word from the FIFO carries its own count of valid bytes. Bytes go out lowest byte first, and each byte goes out most-significant bit first. The byte shifted in during each byte time is stored in the matching byte lane of the receive word. The word is pushed once its last valid byte has completed, together with the number of valid bytes. The divider code, polarity and phase are captured when a word starts, so the inputs may change at any time without damaging a word that is already being shifted.

Top module: `spi_serial_engine`

## Requirements
- R1: The serial clock toggles once every 2^div_i reference cycles while a word is shifting, so its frequency is ref/(2<<div_i). Code 0 therefore divides by 2.
- R2: While no word is shifting, sclk_o rests at the cpol_i level. This includes the gap between consecutive words.
- R3: Phase selection works as follows. With cpha_i=0, the first data bit is on mosi_o before the first clock edge, data is captured on leading edges and changed on trailing edges. With cpha_i=1, data is changed on leading edges and captured on trailing edges. A leading edge is the move away from the cpol_i level.
- R4: Transmit order is fixed. tx_cnt_i = k means that k+1 bytes are valid. Byte lanes are sent in the order bits 7:0, 15:8, 23:16, 31:24, and each byte is sent MSB first.
- R5: Exactly one rx_push_o pulse follows each word. Received byte i appears in rx_word_o[8i+7:8i], lanes above the valid count read zero, and rx_cnt_o is the valid byte count (1 to 4).
- R6: One cycle after the inputs, cs_n_o is 0 exactly when master_i=1, cs_force_i=1 and cs_sw_i=0, and is 1 otherwise.
- R7: A word starts only when all of the following hold: the engine is idle, tx_empty_i=0, en_i=1, master_i=1 and cs_n_o=0. tx_pop_o pulses for one cycle, in the cycle after the start.
- R8: When the transmit FIFO runs empty, chip select stays asserted and the clock stays idle. Shifting resumes when the next word arrives.
- R9: Changing div_i, cpol_i or cpha_i during a word has no effect on that word.
- R10: Dropping en_i during a word freezes sclk_o. When en_i returns, the word resumes and completes intact.
- R11: When words are queued back to back, the receive push of one word falls in the same cycle as the transmit pop of the next.
- R12: After reset, cs_n_o=1, sclk_o=0, mosi_o=0 and tx_pop_o=rx_push_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Global enable: gates starts and clock edges |
| master_i | input | 1 | Master enable: required for chip select and starts |
| div_i | input | 3 | Divider code, sclk = ref/(2<<code) |
| cpol_i | input | 1 | Idle clock level |
| cpha_i | input | 1 | Clock phase select |
| cs_force_i | input | 1 | Manual chip-select force enable |
| cs_sw_i | input | 1 | Software chip-select bit, 1 = deasserted |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| tx_word_i | input | 32 | Transmit FIFO head word |
| tx_cnt_i | input | 2 | Valid bytes of head word minus one |
| tx_pop_o | output | 1 | Pop pulse to transmit FIFO |
| rx_push_o | output | 1 | Push pulse to receive FIFO |
| rx_word_o | output | 32 | Received word |
| rx_cnt_o | output | 3 | Valid bytes in received word |
| sclk_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The delivery of a finished word to the receive side can fall in the same cycle as the fetch of the next transmit word. The bench queues several words at once with the fastest divider and counts the cycles in which rx_push_o and tx_pop_o are both high. It expects exactly one such cycle per word boundary. In the same run, every received word is compared with the loopback expectation and the bit order on mosi_o is checked, which shows that loading a new word did not corrupt the word being handed off.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  // Which clock edge of a bit period captures incoming data.
  typedef enum logic {
    PH_LEAD_CAPTURE = 1'b0,
    PH_LEAD_LAUNCH  = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_eng_clkgen.sv
module spi_eng_clkgen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  output logic             tick,
  output logic             sclk
);
  localparam int CNT_W = 2 ** DIV_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  assign half_m1 = (CNT_W'(1) << div) - CNT_W'(1);
  assign tick    = run && !hold && (cnt_q == half_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      sclk  <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sclk  <= cpol;
    end else if (!hold) begin
      if (cnt_q == half_m1) begin
        cnt_q <= '0;
        sclk  <= ~sclk;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_eng_shifter.sv
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [8*BYTES-1:0]         word_in,
  input  logic [$clog2(BYTES)-1:0]   nb_m1,
  input  logic                       cpha,
  input  logic                       tick,
  input  logic                       miso,
  output logic                       busy,
  output logic                       mosi,
  output logic                       done,
  output logic [8*BYTES-1:0]         rx_word
);
  localparam int BITS   = 8 * BYTES;
  localparam int NB_W   = $clog2(BYTES);
  localparam int BIT_W  = $clog2(BITS);
  localparam int EDGE_W = BIT_W + 1;

  logic [BITS-1:0]   word_q;
  logic [EDGE_W-1:0] edge_q;
  logic [NB_W-1:0]   nb_q;
  phase_e            ph_q;

  logic [EDGE_W-1:0] last_edge;
  logic [BIT_W-1:0]  bit_idx;
  logic [BIT_W-1:0]  bit_nxt;
  logic              trailing;
  logic              capture;

  // Serial index -> word bit: byte lanes ascending, MSB first in a lane.
  function automatic logic [BIT_W-1:0] lane_pos(input logic [BIT_W-1:0] i);
    return {i[BIT_W-1:3], ~i[2:0]};
  endfunction

  assign last_edge = {nb_q, 4'b1111};
  assign bit_idx   = edge_q[EDGE_W-1:1];
  assign bit_nxt   = bit_idx + BIT_W'(1);
  assign trailing  = edge_q[0];
  assign capture   = (ph_q == PH_LEAD_CAPTURE) ? !trailing : trailing;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      rx_word <= '0;
      edge_q  <= '0;
      nb_q    <= '0;
      ph_q    <= PH_LEAD_CAPTURE;
      busy    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        word_q  <= word_in;
        rx_word <= '0;
        edge_q  <= '0;
        nb_q    <= nb_m1;
        ph_q    <= phase_e'(cpha);
        busy    <= 1'b1;
        mosi    <= word_in[lane_pos('0)];
      end else if (busy && tick) begin
        edge_q <= edge_q + EDGE_W'(1);
        if (capture) begin
          rx_word[lane_pos(bit_idx)] <= miso;
        end
        if (ph_q == PH_LEAD_CAPTURE) begin
          if (trailing && edge_q != last_edge) begin
            mosi <= word_q[lane_pos(bit_nxt)];
          end
        end else if (!trailing) begin
          mosi <= word_q[lane_pos(bit_idx)];
        end
        if (edge_q == last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine #(
  parameter int BYTES = 4,
  parameter int DIV_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en_i,
  input  logic                       master_i,
  input  logic [DIV_W-1:0]           div_i,
  input  logic                       cpol_i,
  input  logic                       cpha_i,
  input  logic                       cs_force_i,
  input  logic                       cs_sw_i,
  input  logic                       tx_empty_i,
  input  logic [8*BYTES-1:0]         tx_word_i,
  input  logic [$clog2(BYTES)-1:0]   tx_cnt_i,
  output logic                       tx_pop_o,
  output logic                       rx_push_o,
  output logic [8*BYTES-1:0]         rx_word_o,
  output logic [$clog2(BYTES):0]     rx_cnt_o,
  output logic                       sclk_o,
  output logic                       cs_n_o,
  output logic                       mosi_o,
  input  logic                       miso_i
);
  localparam int NB_W = $clog2(BYTES);
  localparam int DW   = 8 * BYTES;

  logic             busy;
  logic             done;
  logic             tick;
  logic             start_w;
  logic [DIV_W-1:0] div_q;
  logic             cpol_q;
  logic [NB_W-1:0]  nb_q;
  logic [DW-1:0]    rx_w;

  assign start_w = !busy && en_i && master_i && !cs_n_o && !tx_empty_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_o    <= 1'b1;
      tx_pop_o  <= 1'b0;
      rx_push_o <= 1'b0;
      rx_word_o <= '0;
      rx_cnt_o  <= '0;
      div_q     <= '0;
      cpol_q    <= 1'b0;
      nb_q      <= '0;
    end else begin
      cs_n_o    <= !(master_i && cs_force_i && !cs_sw_i);
      tx_pop_o  <= start_w;
      rx_push_o <= done;
      if (done) begin
        rx_word_o <= rx_w;
        rx_cnt_o  <= {1'b0, nb_q} + (NB_W+1)'(1);
      end
      if (start_w) begin
        div_q  <= div_i;
        cpol_q <= cpol_i;
        nb_q   <= tx_cnt_i;
      end
    end
  end

  spi_eng_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .hold (!en_i),
    .div  (div_q),
    .cpol (busy ? cpol_q : cpol_i),
    .tick (tick),
    .sclk (sclk_o)
  );

  spi_eng_shifter #(.BYTES(BYTES)) u_shf (
    .clk     (clk),
    .rst     (rst),
    .start   (start_w),
    .word_in (tx_word_i),
    .nb_m1   (tx_cnt_i),
    .cpha    (cpha_i),
    .tick    (tick),
    .miso    (miso_i),
    .busy    (busy),
    .mosi    (mosi_o),
    .done    (done),
    .rx_word (rx_w)
  );
endmodule

// File: rtl/spi_serial_engine_chk.sv
module spi_serial_engine_chk #(
  parameter int BYTES = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en_i,
  input logic                     master_i,
  input logic                     cs_force_i,
  input logic                     cs_sw_i,
  input logic                     tx_empty_i,
  input logic                     tx_pop_o,
  input logic                     rx_push_o,
  input logic [$clog2(BYTES):0]   rx_cnt_o,
  input logic                     sclk_o,
  input logic                     cs_n_o
);
  logic inflight_q;

  always_ff @(posedge clk) begin
    if (rst)            inflight_q <= 1'b0;
    else if (tx_pop_o)  inflight_q <= 1'b1;
    else if (rx_push_o) inflight_q <= 1'b0;
  end

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tx_pop_o |=> !tx_pop_o); // R7

  AST_POP_GATED: assert property (@(posedge clk) disable iff (rst)
    tx_pop_o |-> (!$past(cs_n_o) && $past(en_i) && $past(master_i) && !$past(tx_empty_i))); // R7

  AST_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    (master_i && cs_force_i && !cs_sw_i) |=> !cs_n_o); // R6

  AST_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !(master_i && cs_force_i && !cs_sw_i) |=> cs_n_o); // R6

  AST_PUSH_COUNT: assert property (@(posedge clk) disable iff (rst)
    rx_push_o |-> (rx_cnt_o != '0 && rx_cnt_o <= ($clog2(BYTES)+1)'(BYTES))); // R5

  AST_PUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_push_o |=> !rx_push_o); // R5

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (inflight_q && !en_i) |=> $stable(sclk_o)); // R10
endmodule

bind spi_serial_engine spi_serial_engine_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .master_i   (master_i),
  .cs_force_i (cs_force_i),
  .cs_sw_i    (cs_sw_i),
  .tx_empty_i (tx_empty_i),
  .tx_pop_o   (tx_pop_o),
  .rx_push_o  (rx_push_o),
  .rx_cnt_o   (rx_cnt_o),
  .sclk_o     (sclk_o),
  .cs_n_o     (cs_n_o)
);

// File: tb/tb_spi_serial_engine.sv
`timescale 1ns/1ps
module tb_spi_serial_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 1'b0, master_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0;
  logic cs_force_i = 1'b0, cs_sw_i = 1'b1;
  logic [2:0] div_i = 3'd0;
  logic tx_empty_i;
  logic [31:0] tx_word_i;
  logic [1:0] tx_cnt_i;
  logic tx_pop_o, rx_push_o, sclk_o, cs_n_o, mosi_o, miso_i;
  logic [31:0] rx_word_o;
  logic [2:0] rx_cnt_o;

  always #5 clk = ~clk;

  // Transmit FIFO model and expectation store
  logic [31:0] fifo_w [0:127];
  logic [1:0]  fifo_n [0:127];
  logic        exp_inv[0:127];
  int wr_ptr = 0, rd_ptr = 0, chk_ptr = 0;
  assign tx_empty_i = (rd_ptr == wr_ptr);
  assign tx_word_i  = fifo_w[rd_ptr[6:0]];
  assign tx_cnt_i   = fifo_n[rd_ptr[6:0]];
  always @(posedge clk) if (tx_pop_o) rd_ptr <= rd_ptr + 1;

  logic miso_flip = 1'b0;
  assign miso_i = mosi_o ^ miso_flip;

  spi_serial_engine dut (
    .clk(clk), .rst(rst), .en_i(en_i), .master_i(master_i), .div_i(div_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .cs_force_i(cs_force_i), .cs_sw_i(cs_sw_i),
    .tx_empty_i(tx_empty_i), .tx_word_i(tx_word_i), .tx_cnt_i(tx_cnt_i),
    .tx_pop_o(tx_pop_o), .rx_push_o(rx_push_o), .rx_word_o(rx_word_o),
    .rx_cnt_o(rx_cnt_o), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
    .miso_i(miso_i)
  );

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected configuration of the word in flight
  logic cpol_exp = 1'b0, cpha_exp = 1'b0;
  int   div_exp = 0;

  // Serial monitor state
  logic bits [0:31];
  int   nbits = 0, per_bad = 0, pause_tog = 0, pop_cnt = 0, coincide = 0;
  bit   rec_en = 0, first_tog = 1, no_period = 0, paused = 0;
  time  last_t = 0;
  logic lead;

  always @(sclk_o) begin
    if (rec_en) begin
      if (!first_tog && !no_period && (($time - last_t) != time'((1 << div_exp) * 10))) per_bad++;
      first_tog = 0;
      last_t = $time;
      if (paused) pause_tog++;
      lead = (sclk_o != cpol_exp);
      if (cpha_exp ? !lead : lead) begin
        if (nbits < 32) bits[nbits] = mosi_o;
        nbits++;
      end
    end
  end

  int nb;
  logic [31:0] ew, em;
  bit okb;
  always @(negedge clk) begin
    if (rx_push_o) begin
      nb = int'(fifo_n[chk_ptr[6:0]]) + 1;
      ew = fifo_w[chk_ptr[6:0]];
      em = '0;
      for (int b = 0; b < 4; b++) if (b < nb) em[8*b +: 8] = 8'hFF;
      check(rx_word_o == ((ew ^ {32{exp_inv[chk_ptr[6:0]]}}) & em), "R5 rx word", rx_word_o,
            (ew ^ {32{exp_inv[chk_ptr[6:0]]}}) & em);
      check(rx_cnt_o == 3'(nb), "R5 rx count", 32'(rx_cnt_o), 32'(nb));
      okb = (nbits == 8 * nb);
      for (int s = 0; s < 32; s++)
        if (s < nbits && s < 8 * nb && bits[s] != ew[8*(s/8) + 7 - (s%8)]) okb = 0;
      check(okb, "R3/R4 mosi bit order", 32'(nbits), 32'(8 * nb));
      check(per_bad == 0, "R1 half period", 32'(per_bad), 32'd0);
      check(sclk_o == cpol_exp, "R2 idle level after word", 32'(sclk_o), 32'(cpol_exp));
      if (tx_pop_o) coincide++;
      rec_en = 0;
      chk_ptr++;
    end
    if (tx_pop_o) begin
      nbits = 0; per_bad = 0; first_tog = 1;
      miso_flip = exp_inv[rd_ptr[6:0]];
      rec_en = 1;
      pop_cnt++;
    end
  end

  task automatic enq(input logic [31:0] w, input logic [1:0] n, input logic inv);
    fifo_w[wr_ptr[6:0]] = w;
    fifo_n[wr_ptr[6:0]] = n;
    exp_inv[wr_ptr[6:0]] = inv;
    wr_ptr++;
  endtask

  task automatic drain();
    while (chk_ptr != wr_ptr) tick(1);
    tick(2);
  endtask

  task automatic wait_pop();
    int p = pop_cnt;
    while (pop_cnt == p) tick(1);
  endtask

  task automatic set_cfg(input int d, input logic pol, input logic pha);
    div_i = 3'(d); cpol_i = pol; cpha_i = pha;
    div_exp = d; cpol_exp = pol; cpha_exp = pha;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // R12 reset state
    check(cs_n_o == 1'b1, "R12 cs_n after reset", 32'(cs_n_o), 32'd1);
    check(sclk_o == 1'b0, "R12 sclk after reset", 32'(sclk_o), 32'd0);
    check(mosi_o == 1'b0, "R12 mosi after reset", 32'(mosi_o), 32'd0);
    check(!tx_pop_o && !rx_push_o, "R12 strobes after reset", {tx_pop_o, rx_push_o}, 32'd0);

    // R6 chip-select truth table
    for (int c = 0; c < 8; c++) begin
      master_i = c[2]; cs_force_i = c[1]; cs_sw_i = c[0];
      tick(2);
      check(cs_n_o == !(c[2] && c[1] && !c[0]), "R6 cs_n vs force/sw/master",
            32'(cs_n_o), 32'(!(c[2] && c[1] && !c[0])));
    end

    // R7 start gating
    set_cfg(0, 1'b0, 1'b0);
    master_i = 1'b1; cs_force_i = 1'b1; cs_sw_i = 1'b1; en_i = 1'b1;
    enq(32'h1234_5678, 2'd3, 1'b0);
    tick(40);
    check(pop_cnt == 0, "R7 no start with cs deasserted", 32'(pop_cnt), 32'd0);
    cs_sw_i = 1'b0; en_i = 1'b0;
    tick(40);
    check(pop_cnt == 0, "R7 no start with enable low", 32'(pop_cnt), 32'd0);
    check(sclk_o == 1'b0, "R2 idle while blocked", 32'(sclk_o), 32'd0);
    en_i = 1'b1;
    drain();
    check(pop_cnt == 1, "R7 start once conditions hold", 32'(pop_cnt), 32'd1);

    // Sweep: polarity x phase x divider x byte count (R1 R2 R3 R4 R5)
    for (int k = 0; k < 64; k++) begin
      set_cfg((k >> 2) & 3, k[5], k[4]);
      tick(2);
      enq(32'h9E37_79B9 * 32'(k + 1), 2'(k & 3), k[0] ^ k[3]);
      drain();
    end

    // R11 back-to-back words
    set_cfg(0, 1'b0, 1'b0);
    tick(2);
    coincide = 0;
    enq(32'hDEAD_BEEF, 2'd3, 1'b0);
    enq(32'h0F1E_2D3C, 2'd0, 1'b1);
    enq(32'hA5A5_5A5A, 2'd1, 1'b0);
    drain();
    check(coincide == 2, "R11 push and pop share a cycle", 32'(coincide), 32'd2);

    // R8 underflow gap keeps chip select
    set_cfg(1, 1'b1, 1'b0);
    tick(2);
    enq(32'h1357_9BDF, 2'd2, 1'b1);
    drain();
    tick(30);
    check(cs_n_o == 1'b0, "R8 cs held across empty FIFO", 32'(cs_n_o), 32'd0);
    check(sclk_o == 1'b1, "R8 clock idle across gap", 32'(sclk_o), 32'd1);
    enq(32'h2468_ACE0, 2'd3, 1'b0);
    drain();
    check(cs_n_o == 1'b0, "R8 cs still held after resume", 32'(cs_n_o), 32'd0);

    // R9 configuration changes mid-word are ignored
    set_cfg(1, 1'b1, 1'b1);
    tick(2);
    enq(32'hC001_D00D, 2'd3, 1'b1);
    wait_pop();
    tick(3);
    div_i = 3'd3; cpol_i = 1'b0; cpha_i = 1'b0;
    tick(12);
    div_i = 3'd1; cpol_i = 1'b1; cpha_i = 1'b1;
    drain();
    check(n_bad == 0, "R9 word intact after mid-word config change", 32'(n_bad), 32'd0);

    // R10 enable pause
    set_cfg(0, 1'b0, 1'b1);
    tick(2);
    enq(32'h7E57_0B1E, 2'd3, 1'b0);
    wait_pop();
    tick(4);
    no_period = 1; paused = 1; pause_tog = 0;
    en_i = 1'b0;
    tick(20);
    check(pause_tog == 0, "R10 clock frozen while disabled", 32'(pause_tog), 32'd0);
    paused = 0;
    en_i = 1'b1;
    drain();
    no_period = 0;
    check(pop_cnt == wr_ptr, "R10 all words fetched", 32'(pop_cnt), 32'(wr_ptr));

    summary();
    $finish;
  end
endmodule